// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches 31 GPIO input pins, which arrive already synchronised to the block clock. For each pin it tracks four interrupt conditions: the pin is low, the pin is high, the pin went from high to low, and the pin went from low to high. The conditions are kept in three register banks that software reaches over a simple 32-bit word bus. An enable bank selects which conditions may interrupt. A raw bank shows every condition, enabled or not. A masked bank shows only the raw conditions that are also enabled.

Each pin owns a 4-bit field. Eight fields are packed into one 32-bit word, so 31 pins take four words. Edge conditions are sticky. Software clears them by writing ones into the raw bank. Level conditions always show the present pin value. A single interrupt request line is raised whenever any masked condition is active.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset all enable bits are 0, all edge bits in the raw bank are 0, `irq_o` is 0 and `rd_valid_o` is 0.
- R2: Pin n lives in word n/8 at bits 4*(n mod 8) to 4*(n mod 8)+3. Within a field, bit 0 is low level, bit 1 is high level, bit 2 is falling edge and bit 3 is rising edge.
- R3: The address is {bank[1:0], word[1:0]}. Bank 0 is the enable bank (read/write), bank 1 is the masked bank (read only), bank 2 is the raw bank (write one to clear) and bank 3 always reads zero.
- R4: A read accepted on a clock edge with `rd_en_i` high returns its word on `rd_data_o` with `rd_valid_o` high after the next clock edge. In every other cycle `rd_valid_o` is low.
- R5: The rising or falling edge bit of a pin is set on the first clock edge at which the pin differs from its value sampled on the previous clock edge. The bit can be read from the next cycle on.
- R6: Writing 1 to an edge bit in the raw bank clears it, and writing 0 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the bit stays set.
- R7: The level bits always show the present pin value and writes to the raw bank do not change them.
- R8: Each masked bank word equals the bitwise AND of the raw word and the enable word.
- R9: `irq_o` is high exactly when at least one masked bit is set.
- R10: Bits 28 to 31 of word 3 belong to no pin. They read as zero in every bank and writes to them are ignored.
- R11: The pin values present when reset is released do not produce any edge bit.
- R12: Writes to the masked bank or to bank 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 31 | Synchronised pin levels |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Write address {bank, word} |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 4 | Read address {bank, word} |
| rd_data_o | output | 32 | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the pins are already synchronous to `clk`, that a pin changes at most once per clock, and that the read and write strobes are single-cycle pulses whose address is held while the strobe is high. The stimulus changes pins and bus signals only on the falling clock edge. It holds each pin value for at least one full cycle, and it issues at most one read and one write per cycle. The single exception is a deliberate case in which a pin edge and a clear of that same bit arrive in the same cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int COND_W = 4;
    localparam int DATA_W = 32;
    localparam int FIELDS_PER_WORD = DATA_W / COND_W;

    // Packed so that low level is bit 0 and rising edge is bit 3.
    typedef struct packed {
        logic rise;
        logic fall;
        logic high;
        logic low;
    } cond_t;

    typedef enum logic [1:0] {
        BANK_EN     = 2'd0,
        BANK_MASKED = 2'd1,
        BANK_RAW    = 2'd2,
        BANK_NONE   = 2'd3
    } bank_e;

    function automatic int words_for(input int pins);
        return (pins + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
    endfunction

    function automatic int word_aw_for(input int pins);
        return (words_for(pins) > 1) ? $clog2(words_for(pins)) : 1;
    endfunction

endpackage

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 31
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PINS-1:0]  pins_i,
    output cond_t [NUM_PINS-1:0] cond_o
);

    logic [NUM_PINS-1:0] prev_q;
    logic                armed_q;

    // armed_q stays low for the first cycle after reset so that the
    // initial pin levels are taken as history, not as edges.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= pins_i;
            armed_q <= 1'b1;
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign cond_o[p].low  = ~pins_i[p];
        assign cond_o[p].high = pins_i[p];
        assign cond_o[p].fall = armed_q & ~pins_i[p] & prev_q[p];
        assign cond_o[p].rise = armed_q & pins_i[p] & ~prev_q[p];
    end

endmodule

// File: rtl/gpio_irq_raw.sv
module gpio_irq_raw
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 31,
    localparam int WORD_AW = word_aw_for(NUM_PINS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cond_t [NUM_PINS-1:0] cond_i,
    input  logic                 clr_en_i,
    input  logic [WORD_AW-1:0]   clr_word_i,
    input  logic [DATA_W-1:0]    clr_data_i,
    output cond_t [NUM_PINS-1:0] raw_o
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int W = p / FIELDS_PER_WORD;
        localparam int F = p % FIELDS_PER_WORD;

        logic rise_q, fall_q;
        logic hit;

        assign hit = clr_en_i && (clr_word_i == WORD_AW'(W));

        // A new edge wins over a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (rst) begin
                rise_q <= 1'b0;
                fall_q <= 1'b0;
            end else begin
                rise_q <= (rise_q & ~(hit & clr_data_i[F*COND_W+3])) | cond_i[p].rise;
                fall_q <= (fall_q & ~(hit & clr_data_i[F*COND_W+2])) | cond_i[p].fall;
            end
        end

        assign raw_o[p].rise = rise_q;
        assign raw_o[p].fall = fall_q;
        assign raw_o[p].high = cond_i[p].high;
        assign raw_o[p].low  = cond_i[p].low;
    end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 31,
    localparam int NUM_WORDS = words_for(NUM_PINS),
    localparam int WORD_AW = word_aw_for(NUM_PINS),
    localparam int ADDR_W = WORD_AW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cond_t [NUM_PINS-1:0] raw_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic                 rd_valid_o,
    output logic                 clr_en_o,
    output logic [WORD_AW-1:0]   clr_word_o,
    output logic [DATA_W-1:0]    clr_data_o,
    output logic                 irq_o
);

    localparam int FLAT_W = NUM_WORDS * DATA_W;
    localparam int USED_W = NUM_PINS * COND_W;

    cond_t [NUM_PINS-1:0] en_q;
    bank_e                wr_bank, rd_bank;
    logic [WORD_AW-1:0]   wr_word, rd_word;
    logic [FLAT_W-1:0]    raw_flat, en_flat;
    logic [DATA_W-1:0]    rd_next;

    assign wr_bank = bank_e'(wr_addr_i[ADDR_W-1 -: 2]);
    assign wr_word = wr_addr_i[WORD_AW-1:0];
    assign rd_bank = bank_e'(rd_addr_i[ADDR_W-1 -: 2]);
    assign rd_word = rd_addr_i[WORD_AW-1:0];

    // Enable fields: only bits that belong to a real pin are stored.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_en
        localparam int W = p / FIELDS_PER_WORD;
        localparam int F = p % FIELDS_PER_WORD;
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[p] <= '0;
            end else if (wr_en_i && wr_bank == BANK_EN && wr_word == WORD_AW'(W)) begin
                en_q[p] <= cond_t'(wr_data_i[F*COND_W +: COND_W]);
            end
        end
    end

    assign clr_en_o   = wr_en_i && (wr_bank == BANK_RAW);
    assign clr_word_o = wr_word;
    assign clr_data_o = wr_data_i;

    always_comb begin
        raw_flat = '0;
        en_flat  = '0;
        raw_flat[USED_W-1:0] = raw_i;
        en_flat[USED_W-1:0]  = en_q;
    end

    always_comb begin
        rd_next = '0;
        if (int'(rd_word) < NUM_WORDS) begin
            unique case (rd_bank)
                BANK_EN:     rd_next = en_flat[int'(rd_word)*DATA_W +: DATA_W];
                BANK_MASKED: rd_next = raw_flat[int'(rd_word)*DATA_W +: DATA_W]
                                     & en_flat[int'(rd_word)*DATA_W +: DATA_W];
                BANK_RAW:    rd_next = raw_flat[int'(rd_word)*DATA_W +: DATA_W];
                default:     rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_en_i;
            if (rd_en_i) begin
                rd_data_o <= rd_next;
            end
        end
    end

    assign irq_o = |(raw_i & en_q);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 31,
    localparam int WORD_AW = word_aw_for(NUM_PINS),
    localparam int ADDR_W = WORD_AW + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                rd_valid_o,
    output logic                irq_o
);

    cond_t [NUM_PINS-1:0] ev_cond;
    cond_t [NUM_PINS-1:0] raw_cond;
    logic                 clr_en;
    logic [WORD_AW-1:0]   clr_word;
    logic [DATA_W-1:0]    clr_data;

    gpio_irq_edge #(.NUM_PINS(NUM_PINS)) i_edge (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_i),
        .cond_o (ev_cond)
    );

    gpio_irq_raw #(.NUM_PINS(NUM_PINS)) i_raw (
        .clk        (clk),
        .rst        (rst),
        .cond_i     (ev_cond),
        .clr_en_i   (clr_en),
        .clr_word_i (clr_word),
        .clr_data_i (clr_data),
        .raw_o      (raw_cond)
    );

    gpio_irq_regs #(.NUM_PINS(NUM_PINS)) i_regs (
        .clk        (clk),
        .rst        (rst),
        .raw_i      (raw_cond),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_en_i    (rd_en_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .clr_en_o   (clr_en),
        .clr_word_o (clr_word),
        .clr_data_o (clr_data),
        .irq_o      (irq_o)
    );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 31,
    localparam int NUM_WORDS = words_for(NUM_PINS),
    localparam int WORD_AW = word_aw_for(NUM_PINS),
    localparam int ADDR_W = WORD_AW + 2,
    localparam int PAD_W = NUM_WORDS * DATA_W - NUM_PINS * COND_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en_i,
    input logic [ADDR_W-1:0]    wr_addr_i,
    input logic [DATA_W-1:0]    wr_data_i,
    input logic                 rd_en_i,
    input logic [ADDR_W-1:0]    rd_addr_i,
    input logic [DATA_W-1:0]    rd_data_o,
    input logic                 rd_valid_o,
    input logic                 irq_o,
    input cond_t [NUM_PINS-1:0] ev_cond,
    input cond_t [NUM_PINS-1:0] raw_cond
);

    // R4
    rd_valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en_i |=> rd_valid_o);

    // R4
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> !rd_valid_o);

    // R9
    quiet_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && rd_addr_i[ADDR_W-1 -: 2] == BANK_MASKED && !irq_o)
        |=> (rd_data_o == '0));

    if (PAD_W > 0) begin : g_pad
        // R10
        unused_bits_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_en_i && int'(rd_addr_i[WORD_AW-1:0]) == NUM_WORDS - 1)
            |=> (rd_data_o[DATA_W-1 -: PAD_W] == '0));
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int W = p / FIELDS_PER_WORD;
        localparam int F = p % FIELDS_PER_WORD;

        logic clr_rise, clr_fall;
        assign clr_rise = wr_en_i && wr_addr_i[ADDR_W-1 -: 2] == BANK_RAW
                          && wr_addr_i[WORD_AW-1:0] == WORD_AW'(W)
                          && wr_data_i[F*COND_W+3];
        assign clr_fall = wr_en_i && wr_addr_i[ADDR_W-1 -: 2] == BANK_RAW
                          && wr_addr_i[WORD_AW-1:0] == WORD_AW'(W)
                          && wr_data_i[F*COND_W+2];

        // R5
        rise_latch_chk: assert property (@(posedge clk) disable iff (rst)
            ev_cond[p].rise |=> raw_cond[p].rise);

        // R5
        fall_latch_chk: assert property (@(posedge clk) disable iff (rst)
            ev_cond[p].fall |=> raw_cond[p].fall);

        // R6
        rise_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (raw_cond[p].rise && !clr_rise) |=> raw_cond[p].rise);

        // R6
        fall_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (raw_cond[p].fall && !clr_fall) |=> raw_cond[p].fall);
    end

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NUM_PINS(NUM_PINS)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .irq_o      (irq_o),
    .ev_cond    (ev_cond),
    .raw_cond   (raw_cond)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 31;
    localparam int WATCHDOG = 20000;

    localparam logic [1:0] B_EN = 2'd0, B_MSK = 2'd1, B_RAW = 2'd2, B_NONE = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [30:0] pins = 31'h0000_0021;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Bench model
    logic [3:0]  m_en [NP];
    logic [30:0] m_rise = '0;
    logic [30:0] m_fall = '0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk        (clk),
        .rst        (rst),
        .pins_i     (pins),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_en_i    (rd_en),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .rd_valid_o (rd_valid),
        .irq_o      (irq)
    );

    function automatic logic [3:0] raw_field(input int p);
        // bit0 low, bit1 high, bit2 fall, bit3 rise
        return {m_rise[p], m_fall[p], pins[p], ~pins[p]};
    endfunction

    function automatic logic [31:0] exp_word(input logic [1:0] bank, input int w);
        logic [31:0] v = '0;
        for (int f = 0; f < 8; f++) begin
            int p = w * 8 + f;
            if (p < NP) begin
                case (bank)
                    B_EN:    v[f*4 +: 4] = m_en[p];
                    B_MSK:   v[f*4 +: 4] = raw_field(p) & m_en[p];
                    B_RAW:   v[f*4 +: 4] = raw_field(p);
                    default: v[f*4 +: 4] = 4'h0;
                endcase
            end
        end
        return v;
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int p = 0; p < NP; p++) r |= |(raw_field(p) & m_en[p]);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_pins(input logic [30:0] v);
        m_rise |= v & ~pins;
        m_fall |= ~v & pins;
    endtask

    task automatic model_write(input logic [3:0] a, input logic [31:0] d);
        for (int f = 0; f < 8; f++) begin
            int p = int'(a[1:0]) * 8 + f;
            if (p < NP) begin
                if (a[3:2] == B_EN) m_en[p] = d[f*4 +: 4];
                if (a[3:2] == B_RAW) begin
                    if (d[f*4+3]) m_rise[p] = 1'b0;
                    if (d[f*4+2]) m_fall[p] = 1'b0;
                end
            end
        end
    endtask

    task automatic set_pins(input logic [30:0] v);
        @(negedge clk);
        model_pins(v);
        pins = v;
    endtask

    task automatic bus_write(input logic [1:0] bank, input int w, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = {bank, 2'(w)};
        wr_data = d;
        model_write(wr_addr, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver side of the scoreboard: push expected read data.
    task automatic bus_read(input logic [1:0] bank, input int w, input string req);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = {bank, 2'(w)};
        exp_q.push_back(exp_word(bank, w));
        tag_q.push_back(req);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic check_irq(input string req);
        @(negedge clk);
        check(irq == exp_irq(), req, 32'(irq), 32'(exp_irq()));
    endtask

    // Monitor side of the scoreboard.
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected rd_valid", rd_data, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) m_en[p] = 4'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'h0);
        check(rd_valid == 1'b0, "R1 rd_valid after reset", 32'(rd_valid), 32'h0);
        @(negedge clk);
        // R11 no edges from reset-time pin levels; R2 R7 field layout of levels
        for (int w = 0; w < 4; w++) bus_read(B_RAW, w, "R11 R2 raw after reset");
        for (int w = 0; w < 4; w++) bus_read(B_EN, w, "R1 enables after reset");

        // R9 enable pin1 rising edge, no edge yet
        bus_write(B_EN, 0, 32'h0000_0080);
        check_irq("R9 no masked bits");
        set_pins(pins | 31'h2);
        check_irq("R9 irq on enabled rising edge");
        bus_read(B_RAW, 0, "R5 rise latched pin1");
        bus_read(B_MSK, 0, "R8 masked word0");

        // R6 write zero has no effect, write ones clears edges only
        bus_write(B_RAW, 0, 32'h0);
        bus_read(B_RAW, 0, "R6 zero write keeps edges");
        bus_write(B_RAW, 0, 32'hFFFF_FFFF);
        bus_read(B_RAW, 0, "R6 R7 clear edges keeps levels");
        check_irq("R9 irq low after clear");

        // R10 unused bits of word 3
        bus_write(B_EN, 3, 32'hFFFF_FFFF);
        model_write({B_EN, 2'd3}, 32'h0);
        for (int p = 24; p < NP; p++) m_en[p] = 4'hF;
        bus_read(B_EN, 3, "R10 enable word3 upper bits");
        bus_write(B_EN, 3, 32'h0);
        // R5 pin 30 rise then fall
        set_pins(pins | 31'h4000_0000);
        set_pins(pins & ~31'h4000_0000);
        bus_read(B_RAW, 3, "R5 R2 pin30 rise and fall");
        bus_read(B_NONE, 3, "R3 bank3 reads zero");

        // R7 level enable on pin 9 high (word1 bit 5)
        bus_write(B_EN, 1, 32'h0000_0020);
        check_irq("R7 level low no irq");
        set_pins(pins | 31'h200);
        check_irq("R7 level high irq");
        bus_write(B_RAW, 1, 32'hFFFF_FFFF);
        check_irq("R7 level survives raw clear");
        bus_read(B_MSK, 1, "R8 masked level word1");
        set_pins(pins & ~31'h200);
        check_irq("R7 level gone");

        // R12 writes to masked bank and bank3 are ignored
        bus_write(B_MSK, 1, 32'hFFFF_FFFF);
        bus_write(B_NONE, 1, 32'hFFFF_FFFF);
        bus_read(B_EN, 1, "R12 enable unchanged");
        bus_read(B_RAW, 1, "R12 raw unchanged");
        bus_read(B_NONE, 1, "R3 bank3 word1 zero");

        // R6 edge on pin 2 in the same cycle as its clear: edge wins
        bus_write(B_RAW, 0, 32'hFFFF_FFFF);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = {B_RAW, 2'd0};
        wr_data = 32'h0000_0800;
        model_write(wr_addr, wr_data);
        model_pins(pins | 31'h4);
        pins = pins | 31'h4;
        @(negedge clk);
        wr_en = 1'b0;
        bus_read(B_RAW, 0, "R6 edge beats clear");

        // Several pin patterns with all conditions enabled
        for (int w = 0; w < 4; w++) bus_write(B_EN, w, 32'hFFFF_FFFF);
        for (int p = 0; p < NP; p++) m_en[p] = 4'hF;
        set_pins(31'h5A5A_1234);
        for (int w = 0; w < 4; w++) bus_read(B_RAW, w, "R5 R2 pattern A raw");
        set_pins(31'h25A5_EDCB);
        for (int w = 0; w < 4; w++) bus_read(B_MSK, w, "R8 pattern B masked");
        check_irq("R9 irq pattern B");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4 all reads returned", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule